// File: doc/BRIEF.md
# Loop Flag Nesting Control

This block keeps the two bits a DSP program controller needs to track nested hardware loops. The loop-active flag sits at the top bit of the status register. The nested-loop flag sits at the top bit of the mode register. Loop start and loop exit strobes update the pair, as do pushes and pops of the hardware stack. Explicit register writes can also load either bit. A single-instruction repeat leaves both bits alone, and so does entry to an interrupt service routine.

A push moves the active flag into the nested flag and then sets the active flag. A pop moves the nested flag back into the active flag and then clears the nested flag. Because the pair shifts this way, a new loop can open while an outer loop is still running, and closing it brings back the outer loop's state. The block also holds a small data stack. Its write strobe pushes data and its read strobe pops it. When it is full, a push discards the oldest entry. When it is empty, a pop returns zero and raises an underflow pulse.

When several events land in one cycle, the block applies them in a fixed order: register writes first, then the stack write, then loop start, then the stack read, and loop exit last.

Top module: `lfn_ctrl`

## Requirements
- R1: While reset is low and after it is released, `lf_o`, `nl_o`, `hws_rdata_o` and `hws_uflow_o` are all zero.
- R2: A stack write loads the old `lf_o` into `nl_o`, sets `lf_o`, and pushes `hws_wdata_i`. The results are visible one cycle after the strobe.
- R3: A stack read loads the old `nl_o` into `lf_o`, clears `nl_o`, and places the newest stack entry on `hws_rdata_o` one cycle later. `hws_rdata_o` holds that value until the next read.
- R4: With `rep_i` low, loop start behaves like a push on the flag pair: `nl_o` takes `lf_o` and `lf_o` becomes 1. Loop exit behaves like a pop on the flag pair: `lf_o` takes `nl_o` and `nl_o` becomes 0.
- R5: While `rep_i` is high, loop start and loop exit change neither flag.
- R6: `irq_entry_i` changes neither flag.
- R7: A status register write loads `lf_o` from bit 15 of `sr_wdata_i`. A mode register write loads `nl_o` from bit 15 of `omr_wdata_i`. All other data bits are ignored.
- R8: The stack holds two entries. A push while full discards the oldest entry, and later pops return entries newest first.
- R9: A read of the empty stack returns zero on `hws_rdata_o` and sets `hws_uflow_o` for exactly one cycle. Any other read leaves `hws_uflow_o` low.
- R10: Events in one cycle apply in this order: register writes, stack write, loop start, stack read, loop exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loop_start_i | input | 1 | Loop start strobe |
| loop_exit_i | input | 1 | Loop exit strobe |
| rep_i | input | 1 | High while a single-instruction repeat runs |
| irq_entry_i | input | 1 | Interrupt service entry strobe |
| hws_wr_i | input | 1 | Hardware stack write strobe |
| hws_wdata_i | input | DW | Data pushed on a stack write |
| hws_rd_i | input | 1 | Hardware stack read strobe |
| sr_wr_i | input | 1 | Status register write strobe |
| sr_wdata_i | input | REG_W | Status register write data |
| omr_wr_i | input | 1 | Mode register write strobe |
| omr_wdata_i | input | REG_W | Mode register write data |
| lf_o | output | 1 | Loop-active flag |
| nl_o | output | 1 | Nested-loop flag |
| hws_rdata_o | output | DW | Entry returned by the last stack read |
| hws_uflow_o | output | 1 | Pulse after a read of the empty stack |

## Verification
The bench drives two loops, one inside the other, and checks that each exit restores the outer flags. A block that cleared the loop flag on the first exit would lose the outer loop. It pushes three entries into the two-deep stack and expects the newest two back. A block that refused a push when full, or that dropped the newest entry, would return the wrong data. It strobes loop start and loop exit while a repeat is running, and also raises interrupt entry; any change to the flags in these cases fails a check. It also sends paired events in one cycle, such as a stack write with a loop exit, or a register write with a push or a pop. A block that applied these in another order would leave different flag values.

// File: rtl/lfn_pkg.sv
package lfn_pkg;
  typedef struct packed {
    logic lf;
    logic nl;
  } lfn_flags_t;

  typedef enum logic {
    STEP_PUSH = 1'b0,
    STEP_POP  = 1'b1
  } lfn_step_e;
endpackage

// File: rtl/lfn_flag_step.sv
module lfn_flag_step
  import lfn_pkg::*;
#(
  parameter lfn_step_e KIND = STEP_PUSH
) (
  input  logic       en_i,
  input  lfn_flags_t cur_i,
  output lfn_flags_t nxt_o
);
  generate
    if (KIND == STEP_PUSH) begin : g_push
      always_comb begin
        nxt_o = cur_i;
        if (en_i) begin
          nxt_o.nl = cur_i.lf;
          nxt_o.lf = 1'b1;
        end
      end
    end else begin : g_pop
      always_comb begin
        nxt_o = cur_i;
        if (en_i) begin
          nxt_o.lf = cur_i.nl;
          nxt_o.nl = 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/lfn_hws.sv
module lfn_hws #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          uflow_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_a [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_a, cnt_d;
  logic [DW-1:0] pop_val;
  logic          uf_d;
  logic [DW-1:0] rdata_q;
  logic          uflow_q;

  // push is applied before pop within a cycle
  always_comb begin
    mem_a = mem_q;
    cnt_a = cnt_q;
    if (push_i) begin
      for (int i = DEPTH - 1; i > 0; i--) mem_a[i] = mem_q[i-1];
      mem_a[0] = wdata_i;
      if (cnt_q != LVL_FULL) cnt_a = cnt_q + 1'b1;
    end
    mem_d   = mem_a;
    cnt_d   = cnt_a;
    pop_val = '0;
    uf_d    = 1'b0;
    if (pop_i) begin
      if (cnt_a == '0) begin
        uf_d = 1'b1;
      end else begin
        pop_val = mem_a[0];
        for (int i = 0; i < DEPTH - 1; i++) mem_d[i] = mem_a[i+1];
        mem_d[DEPTH-1] = '0;
        cnt_d = cnt_a - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      cnt_q   <= '0;
      rdata_q <= '0;
      uflow_q <= 1'b0;
    end else begin
      mem_q   <= mem_d;
      cnt_q   <= cnt_d;
      uflow_q <= uf_d;
      if (pop_i) rdata_q <= pop_val;
    end
  end

  assign rdata_o = rdata_q;
  assign uflow_o = uflow_q;

  p_level_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LVL_FULL);

  p_full_push_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && cnt_q == LVL_FULL) |=> (cnt_q == LVL_FULL));

  p_empty_pop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && cnt_q == '0) |=> (uflow_o && rdata_o == '0));

  p_valid_pop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && cnt_q != '0) |=> !uflow_o);
endmodule

// File: rtl/lfn_ctrl.sv
module lfn_ctrl
  import lfn_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned HWS_DEPTH = 2,
  parameter int unsigned REG_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             loop_start_i,
  input  logic             loop_exit_i,
  input  logic             rep_i,
  input  logic             irq_entry_i,
  input  logic             hws_wr_i,
  input  logic [DW-1:0]    hws_wdata_i,
  input  logic             hws_rd_i,
  input  logic             sr_wr_i,
  input  logic [REG_W-1:0] sr_wdata_i,
  input  logic             omr_wr_i,
  input  logic [REG_W-1:0] omr_wdata_i,
  output logic             lf_o,
  output logic             nl_o,
  output logic [DW-1:0]    hws_rdata_o,
  output logic             hws_uflow_o
);
  localparam int unsigned FLAG_BIT = REG_W - 1;
  localparam int unsigned N_STEPS  = 4;

  lfn_flags_t flags_q;
  lfn_flags_t chain [N_STEPS+1];
  logic [N_STEPS-1:0] step_en;

  logic unused_bits;
  assign unused_bits = ^{sr_wdata_i[FLAG_BIT-1:0], omr_wdata_i[FLAG_BIT-1:0]};

  // stage 0: explicit register writes
  always_comb begin
    chain[0] = flags_q;
    if (sr_wr_i)  chain[0].lf = sr_wdata_i[FLAG_BIT];
    if (omr_wr_i) chain[0].nl = omr_wdata_i[FLAG_BIT];
  end

  // order: stack write, loop start, stack read, loop exit
  assign step_en = {loop_exit_i & ~rep_i, hws_rd_i, loop_start_i & ~rep_i, hws_wr_i};

  generate
    for (genvar g = 0; g < N_STEPS; g++) begin : g_step
      lfn_flag_step #(
        .KIND(g < 2 ? STEP_PUSH : STEP_POP)
      ) u_step (
        .en_i (step_en[g]),
        .cur_i(chain[g]),
        .nxt_o(chain[g+1])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= chain[N_STEPS];
  end

  assign lf_o = flags_q.lf;
  assign nl_o = flags_q.nl;

  lfn_hws #(
    .DW   (DW),
    .DEPTH(HWS_DEPTH)
  ) u_hws (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (hws_wr_i),
    .pop_i  (hws_rd_i),
    .wdata_i(hws_wdata_i),
    .rdata_o(hws_rdata_o),
    .uflow_o(hws_uflow_o)
  );

  logic reg_evt, loop_evt;
  assign reg_evt  = sr_wr_i | omr_wr_i;
  assign loop_evt = (loop_start_i | loop_exit_i) & ~rep_i;

  p_push_flags_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hws_wr_i && !hws_rd_i && !reg_evt && !loop_evt) |=> (lf_o && nl_o == $past(lf_o)));

  p_pop_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hws_rd_i && !hws_wr_i && !reg_evt && !loop_evt) |=> (!nl_o && lf_o == $past(nl_o)));

  p_rep_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_i && !hws_wr_i && !hws_rd_i && !reg_evt) |=> ($stable(lf_o) && $stable(nl_o)));

  p_irq_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_entry_i && !hws_wr_i && !hws_rd_i && !reg_evt && !loop_evt)
      |=> ($stable(lf_o) && $stable(nl_o)));
endmodule

// File: tb/lfn_ctrl_tb.sv
module lfn_ctrl_tb;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_ni;
  logic loop_start, loop_exit, rep, irq_entry, hws_wr, hws_rd, sr_wr, omr_wr;
  logic [DW-1:0] hws_wdata, sr_wdata, omr_wdata;
  logic lf, nl, uflow;
  logic [DW-1:0] rdata;
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lfn_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .loop_start_i(loop_start), .loop_exit_i(loop_exit), .rep_i(rep),
    .irq_entry_i(irq_entry), .hws_wr_i(hws_wr), .hws_wdata_i(hws_wdata),
    .hws_rd_i(hws_rd), .sr_wr_i(sr_wr), .sr_wdata_i(sr_wdata),
    .omr_wr_i(omr_wr), .omr_wdata_i(omr_wdata),
    .lf_o(lf), .nl_o(nl), .hws_rdata_o(rdata), .hws_uflow_o(uflow)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic elf, input logic enl);
    chk(req, "lf", 32'(lf), 32'(elf));
    chk(req, "nl", 32'(nl), 32'(enl));
  endtask

  task automatic idle();
    loop_start = 0; loop_exit = 0; rep = 0; irq_entry = 0;
    hws_wr = 0; hws_rd = 0; sr_wr = 0; omr_wr = 0;
    hws_wdata = '0; sr_wdata = '0; omr_wdata = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic set_flags(input logic vlf, input logic vnl);
    sr_wr = 1; sr_wdata = {vlf, 15'h0};
    omr_wr = 1; omr_wdata = {vnl, 15'h0};
    step();
  endtask

  task automatic t_reset();
    idle();
    rst_ni = 0;
    repeat (3) @(negedge clk);
    chk("R1", "lf in reset", 32'(lf), 0);
    chk("R1", "nl in reset", 32'(nl), 0);
    chk("R1", "rdata in reset", 32'(rdata), 0);
    chk("R1", "uflow in reset", 32'(uflow), 0);
    rst_ni = 1;
    step();
    chk_flags("R1", 0, 0);
  endtask

  task automatic t_regwr();
    sr_wr = 1; sr_wdata = 16'h8000; step();
    chk_flags("R7", 1, 0);
    sr_wr = 1; sr_wdata = 16'h7FFF; step();
    chk_flags("R7", 0, 0);
    omr_wr = 1; omr_wdata = 16'h8000; step();
    chk_flags("R7", 0, 1);
    omr_wr = 1; omr_wdata = 16'h7FFF; step();
    chk_flags("R7", 0, 0);
  endtask

  task automatic t_hws();
    set_flags(0, 0);
    hws_wr = 1; hws_wdata = 16'hA1A1; step();
    chk_flags("R2", 1, 0);
    hws_wr = 1; hws_wdata = 16'hB2B2; step();
    chk_flags("R2", 1, 1);
    hws_rd = 1; step();
    chk_flags("R3", 1, 0);
    chk("R3", "rdata", 32'(rdata), 32'hB2B2);
    step();
    chk("R3", "rdata held", 32'(rdata), 32'hB2B2);
    hws_rd = 1; step();
    chk_flags("R3", 0, 0);
    chk("R3", "rdata", 32'(rdata), 32'hA1A1);
  endtask

  task automatic t_loop();
    set_flags(0, 0);
    loop_start = 1; step();
    chk_flags("R4", 1, 0);
    loop_start = 1; step();
    chk_flags("R4", 1, 1);
    loop_exit = 1; step();
    chk_flags("R4", 1, 0);
    loop_exit = 1; step();
    chk_flags("R4", 0, 0);
  endtask

  task automatic t_rep();
    set_flags(1, 0);
    rep = 1; loop_start = 1; step();
    chk_flags("R5", 1, 0);
    rep = 1; loop_exit = 1; step();
    chk_flags("R5", 1, 0);
    set_flags(0, 1);
    rep = 1; loop_exit = 1; step();
    chk_flags("R5", 0, 1);
  endtask

  task automatic t_irq();
    set_flags(1, 1);
    irq_entry = 1; step();
    chk_flags("R6", 1, 1);
    set_flags(1, 0);
    irq_entry = 1; step();
    chk_flags("R6", 1, 0);
  endtask

  task automatic t_overflow();
    hws_wr = 1; hws_wdata = 16'h0011; step();
    hws_wr = 1; hws_wdata = 16'h0022; step();
    hws_wr = 1; hws_wdata = 16'h0033; step();
    hws_rd = 1; step();
    chk("R8", "pop newest", 32'(rdata), 32'h0033);
    chk("R9", "uflow on valid pop", 32'(uflow), 0);
    hws_rd = 1; step();
    chk("R8", "pop second", 32'(rdata), 32'h0022);
    hws_rd = 1; step();
    chk("R8", "oldest dropped", 32'(rdata), 0);
    chk("R9", "uflow after drop", 32'(uflow), 1);
  endtask

  task automatic t_underflow();
    step();
    hws_wr = 1; hws_wdata = 16'h5A5A; step();
    hws_rd = 1; step();
    chk("R9", "rdata", 32'(rdata), 32'h5A5A);
    hws_rd = 1; step();
    chk("R9", "rdata empty", 32'(rdata), 0);
    chk("R9", "uflow set", 32'(uflow), 1);
    step();
    chk("R9", "uflow one cycle", 32'(uflow), 0);
  endtask

  task automatic t_order();
    set_flags(0, 0);
    hws_wr = 1; hws_wdata = 16'h7777; loop_exit = 1; step();
    chk_flags("R10", 0, 0);
    set_flags(0, 0);
    sr_wr = 1; sr_wdata = 16'h8000; hws_wr = 1; hws_wdata = 16'h1234; step();
    chk_flags("R10", 1, 1);
    set_flags(0, 0);
    omr_wr = 1; omr_wdata = 16'h8000; hws_rd = 1; step();
    chk_flags("R10", 1, 0);
    chk("R10", "rdata", 32'(rdata), 32'h1234);
  endtask

  initial begin
    t_reset();
    t_regwr();
    t_hws();
    t_loop();
    t_rep();
    t_irq();
    t_overflow();
    t_underflow();
    t_order();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule